// File: doc/BRIEF.md
# Segmented Memory Address Mapper

This block turns logical addresses into physical memory targets for a processor whose data and instruction spaces are windowed onto a larger store. A 16-bit data address resolves to one of three places. It can go straight into on-chip data memory, or into an I/O area that faults except for one small 16-byte group. A 16 KiB window can be steered into on-chip instruction memory or into any 16 KiB slice of a 128 KiB unified segment. An 18-bit instruction address resolves through one of two instruction map registers. Bit 17 of the address picks which one. The target is either on-chip instruction memory or a unified segment.

Translation is purely combinational. The three map registers live in the block. They are loaded through a one-word write port, and a change takes effect on the cycle after the write. A per-segment validity vector tells the mapper which unified segments exist. A lookup that lands on a missing segment reports a fault, and so does a lookup into a forbidden I/O address. Data and instruction lookups each carry their own fault. A mode input chosen at reset picks between two sets of reset values for the map registers.

Target codes on both lookup outputs are: 0 = on-chip data memory, 1 = on-chip instruction memory, 2 = unified segment. When the target is not a unified segment, the segment output is 0.

Top module: `segmap_xlat`

## Requirements
- R1: With `legacy_mode` low during reset, the data map resets to 0x0000 and both instruction maps reset to 0x1000. So data address 0x8000 gives target 2, segment 0, offset 0, and instruction address 0x20010 gives target 1 with physical address 0x20010.
- R2: With `legacy_mode` high during reset, the data map resets to 0x0000, instruction map low resets to 0x0000 and instruction map high resets to 0x007F. So instruction address 0x20010 gives target 2, segment 0x7F, offset 0x00010.
- R3: A data address at or below 0x7FFF gives target 0, physical address equal to the address, and no fault.
- R4: A data address from 0xC000 to 0xFFFF gives target 0 with physical address equal to the address. It faults unless bits 15:4 equal 0xFF0.
- R5: For a data address from 0x8000 to 0xBFFF with data-map bit 12 set, the result is target 1 with physical address {map[3:0], addr[13:0]} and no fault.
- R6: For a data address from 0x8000 to 0xBFFF with data-map bit 12 clear, the result is target 2, segment map[9:3] and offset {map[2:0], addr[13:0]}. It faults when that segment's validity bit is 0.
- R7: Instruction address bit 17 set selects instruction map high; clear selects instruction map low.
- R8: When the selected instruction map has bit 12 set, the result is target 1 with physical address equal to the 18-bit instruction address and no fault.
- R9: When the selected instruction map has bit 12 clear, the result is target 2, segment map[6:0] and offset addr[16:0]. It faults when map bit 7 is set (segment 128 or above) or when that segment's validity bit is 0.
- R10: A write with `map_sel` 0, 1 or 2 loads the data map, instruction map low or instruction map high from `map_wdata`, and takes effect from the next cycle. A lookup in the same cycle as the write uses the old value. `map_sel` 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | Selects the alternate reset values while reset is asserted |
| map_we | input | 1 | Map register write enable |
| map_sel | input | 2 | 0 data map, 1 instruction map low, 2 instruction map high, 3 none |
| map_wdata | input | 16 | Value written to the selected map |
| seg_valid | input | 128 | One bit per unified segment, 1 = present |
| d_addr | input | 16 | Logical data address |
| d_tgt | output | 2 | Data target code |
| d_phys | output | 18 | Data physical address or segment offset |
| d_seg | output | 7 | Data unified segment number |
| d_fault | output | 1 | Data lookup fault |
| i_addr | input | 18 | Instruction address |
| i_tgt | output | 2 | Instruction target code |
| i_phys | output | 18 | Instruction physical address or segment offset |
| i_seg | output | 7 | Instruction unified segment number |
| i_fault | output | 1 | Instruction lookup fault |

## Verification
A map register write and a lookup through that same register can fall in one cycle. The lookup must then resolve with the old map value, and the new value must show only from the next cycle. The random phase writes a random map on most cycles and issues data and instruction lookups in those same cycles. A bench model predicts each result from the map values held before the edge, and updates those values only after the edge. Directed steps rewrite the data map while looking up the window address. They then check the old and the new mapping in consecutive cycles.

// File: rtl/segmap_xlat.sv
module segmap_xlat (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         legacy_mode,
  input  logic         map_we,
  input  logic [1:0]   map_sel,
  input  logic [15:0]  map_wdata,
  input  logic [127:0] seg_valid,
  input  logic [15:0]  d_addr,
  output logic [1:0]   d_tgt,
  output logic [17:0]  d_phys,
  output logic [6:0]   d_seg,
  output logic         d_fault,
  input  logic [17:0]  i_addr,
  output logic [1:0]   i_tgt,
  output logic [17:0]  i_phys,
  output logic [6:0]   i_seg,
  output logic         i_fault
);
  localparam logic [1:0]  TGT_DMEM = 2'd0;
  localparam logic [1:0]  TGT_IMEM = 2'd1;
  localparam logic [1:0]  TGT_UMEM = 2'd2;
  localparam logic [15:0] RST_IMAP = 16'h1000;
  localparam logic [15:0] LEG_IMAP_HI = 16'h007F;

  logic [15:0] dmap_q, imap0_q, imap1_q;
  logic [15:0] imap_cur;
  logic        d_io, d_win;
  logic        unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmap_q  <= '0;
      imap0_q <= legacy_mode ? 16'h0000 : RST_IMAP;
      imap1_q <= legacy_mode ? LEG_IMAP_HI : RST_IMAP;
    end else if (map_we) begin
      case (map_sel)
        2'd0:    dmap_q  <= map_wdata;
        2'd1:    imap0_q <= map_wdata;
        2'd2:    imap1_q <= map_wdata;
        default: ;
      endcase
    end
  end

  assign d_io  = (d_addr[15:14] == 2'b11);
  assign d_win = (d_addr[15:14] == 2'b10);

  always_comb begin
    d_tgt   = TGT_DMEM;
    d_phys  = {2'b00, d_addr};
    d_seg   = '0;
    d_fault = 1'b0;
    if (d_io) begin
      d_fault = (d_addr[15:4] != 12'hFF0);
    end else if (d_win) begin
      if (dmap_q[12]) begin
        d_tgt  = TGT_IMEM;
        d_phys = {dmap_q[3:0], d_addr[13:0]};
      end else begin
        d_tgt   = TGT_UMEM;
        d_seg   = dmap_q[9:3];
        d_phys  = {1'b0, dmap_q[2:0], d_addr[13:0]};
        d_fault = !seg_valid[dmap_q[9:3]];
      end
    end
  end

  assign imap_cur = i_addr[17] ? imap1_q : imap0_q;

  always_comb begin
    if (imap_cur[12]) begin
      i_tgt   = TGT_IMEM;
      i_phys  = i_addr;
      i_seg   = '0;
      i_fault = 1'b0;
    end else begin
      i_tgt   = TGT_UMEM;
      i_phys  = {1'b0, i_addr[16:0]};
      i_seg   = imap_cur[6:0];
      i_fault = imap_cur[7] | !seg_valid[imap_cur[6:0]];
    end
  end

  assign unused_bits = ^{dmap_q[15:13], dmap_q[11:10], imap_cur[15:13], imap_cur[11:8]};
endmodule

// File: rtl/segmap_xlat_chk.sv
module segmap_xlat_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         map_we,
  input logic [1:0]   map_sel,
  input logic [15:0]  map_wdata,
  input logic [127:0] seg_valid,
  input logic [15:0]  d_addr,
  input logic [1:0]   d_tgt,
  input logic [17:0]  d_phys,
  input logic [6:0]   d_seg,
  input logic         d_fault,
  input logic [17:0]  i_addr,
  input logic [1:0]   i_tgt,
  input logic [17:0]  i_phys,
  input logic [6:0]   i_seg,
  input logic         i_fault,
  input logic [15:0]  dmap_q,
  input logic [15:0]  imap0_q,
  input logic [15:0]  imap1_q
);
  a_r3_low_direct: assert property (@(posedge clk) disable iff (!rst_n)
    !d_addr[15] |-> (d_tgt == 2'd0 && d_phys == {2'b00, d_addr} && !d_fault));

  a_r4_io_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (d_addr[15:14] == 2'b11 && d_addr[15:4] != 12'hFF0) |-> (d_fault && d_tgt == 2'd0));

  a_r6_missing_seg: assert property (@(posedge clk) disable iff (!rst_n)
    (d_tgt == 2'd2 && !seg_valid[d_seg]) |-> d_fault);

  a_r8_direct_imem: assert property (@(posedge clk) disable iff (!rst_n)
    (i_tgt == 2'd1) |-> (i_phys == i_addr && !i_fault && i_seg == 7'd0));

  a_r9_umem_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (i_tgt == 2'd2) |-> (i_phys[17] == 1'b0 && i_phys[16:0] == i_addr[16:0]));

  a_r10_dmap_load: assert property (@(posedge clk) disable iff (!rst_n)
    (map_we && map_sel == 2'd0) |=> (dmap_q == $past(map_wdata)));

  a_r10_sel3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (map_we && map_sel == 2'd3) |=> ($stable(dmap_q) && $stable(imap0_q) && $stable(imap1_q)));
endmodule

bind segmap_xlat segmap_xlat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_sel(map_sel), .map_wdata(map_wdata),
  .seg_valid(seg_valid), .d_addr(d_addr), .d_tgt(d_tgt), .d_phys(d_phys), .d_seg(d_seg),
  .d_fault(d_fault), .i_addr(i_addr), .i_tgt(i_tgt), .i_phys(i_phys), .i_seg(i_seg),
  .i_fault(i_fault), .dmap_q(dmap_q), .imap0_q(imap0_q), .imap1_q(imap1_q)
);

// File: tb/sim_segmap_xlat.sv
module sim_segmap_xlat;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, legacy_mode, map_we;
  logic [1:0] map_sel;
  logic [15:0] map_wdata, d_addr;
  logic [127:0] seg_valid;
  logic [1:0] d_tgt, i_tgt;
  logic [17:0] d_phys, i_phys, i_addr;
  logic [6:0] d_seg, i_seg;
  logic d_fault, i_fault;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_dmap, m_imap0, m_imap1;

  segmap_xlat u0 (.*);

  function automatic logic [27:0] exp_d(logic [15:0] a);
    logic [1:0] t = 2'd0; logic [17:0] p = {2'b00, a}; logic [6:0] s = 7'd0; logic f = 1'b0;
    if (a >= 16'hC000) f = (a[15:4] != 12'hFF0);
    else if (a >= 16'h8000) begin
      if (m_dmap[12]) begin t = 2'd1; p = {m_dmap[3:0], a[13:0]}; end
      else begin t = 2'd2; s = m_dmap[9:3]; p = {1'b0, m_dmap[2:0], a[13:0]}; f = !seg_valid[s]; end
    end
    return {t, p, s, f};
  endfunction

  function automatic logic [27:0] exp_i(logic [17:0] a);
    logic [15:0] m = a[17] ? m_imap1 : m_imap0;
    if (m[12]) return {2'd1, a, 7'd0, 1'b0};
    return {2'd2, 1'b0, a[16:0], m[6:0], (m[7] | !seg_valid[m[6:0]])};
  endfunction

  function automatic string dreq(logic [15:0] a);
    if (a < 16'h8000) return "R3";
    if (a >= 16'hC000) return "R4";
    return m_dmap[12] ? "R5" : "R6";
  endfunction

  function automatic string ireq(logic [17:0] a);
    logic [15:0] m = a[17] ? m_imap1 : m_imap0;
    return m[12] ? "R7,R8" : "R7,R9";
  endfunction

  task automatic chk(string tag, logic [27:0] act, logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic we, logic [1:0] sel, logic [15:0] wd, logic [15:0] da, logic [17:0] ia, string tag);
    @(negedge clk);
    map_we = we; map_sel = sel; map_wdata = wd; d_addr = da; i_addr = ia;
    #2;
    chk((tag == "") ? dreq(da) : tag, {d_tgt, d_phys, d_seg, d_fault}, exp_d(da));
    chk((tag == "") ? ireq(ia) : tag, {i_tgt, i_phys, i_seg, i_fault}, exp_i(ia));
    @(posedge clk); #1;
    if (we) begin
      case (sel)
        2'd0: m_dmap = wd;
        2'd1: m_imap0 = wd;
        2'd2: m_imap1 = wd;
        default: ;
      endcase
    end
  endtask

  task automatic do_reset(logic leg);
    @(negedge clk);
    rst_n = 1'b0; legacy_mode = leg; map_we = 1'b0;
    m_dmap = 16'h0000;
    m_imap0 = leg ? 16'h0000 : 16'h1000;
    m_imap1 = leg ? 16'h007F : 16'h1000;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; legacy_mode = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; legacy_mode = 1'b0; map_we = 1'b0; map_sel = 2'd0; map_wdata = '0;
    d_addr = '0; i_addr = '0; seg_valid = '1;
    m_dmap = '0; m_imap0 = 16'h1000; m_imap1 = 16'h1000;

    do_reset(1'b0);
    step(1'b0, 2'd0, 16'h0, 16'h8000, 18'h20010, "R1");
    step(1'b0, 2'd0, 16'h0, 16'h0000, 18'h00004, "R1");
    do_reset(1'b1);
    step(1'b0, 2'd0, 16'h0, 16'h8004, 18'h20010, "R2");
    step(1'b0, 2'd0, 16'h0, 16'h0000, 18'h00005, "R2");

    step(1'b1, 2'd0, 16'h1005, 16'h8010, 18'h00000, "R10 same-cycle old map");
    step(1'b0, 2'd0, 16'h0, 16'h8010, 18'h00000, "R10,R5 new map");
    step(1'b1, 2'd3, 16'hFFFF, 16'hBFFF, 18'h3FFFF, "R10 sel3");
    step(1'b0, 2'd0, 16'h0, 16'hBFFF, 18'h3FFFF, "R10 sel3 no effect");
    step(1'b0, 2'd0, 16'h0, 16'h7FFF, 18'h00000, "R3 edge");
    step(1'b0, 2'd0, 16'h0, 16'hFF00, 18'h00000, "R4 io ok");
    step(1'b0, 2'd0, 16'h0, 16'hFF0F, 18'h00000, "R4 io ok");
    step(1'b0, 2'd0, 16'h0, 16'hFF10, 18'h00000, "R4 io fault");
    step(1'b0, 2'd0, 16'h0, 16'hC000, 18'h00000, "R4 io fault");
    step(1'b0, 2'd0, 16'h0, 16'hFFFF, 18'h00000, "R4 io fault");
    seg_valid[5] = 1'b0;
    step(1'b1, 2'd0, 16'h002B, 16'h0000, 18'h00000, "R10");
    step(1'b0, 2'd0, 16'h0, 16'hBFFF, 18'h00000, "R6 missing seg");
    step(1'b1, 2'd1, 16'h0085, 16'h0000, 18'h00100, "R10");
    step(1'b0, 2'd0, 16'h0, 16'h0000, 18'h00100, "R9 seg over 127");
    step(1'b1, 2'd1, 16'h0005, 16'h0000, 18'h00100, "R10");
    step(1'b0, 2'd0, 16'h0, 16'h0000, 18'h1FFFF, "R9 missing seg");
    step(1'b1, 2'd2, 16'h1000, 16'h0000, 18'h00000, "R10");
    step(1'b0, 2'd0, 16'h0, 16'h0000, 18'h3FFFF, "R7,R8 high map");

    for (int n = 0; n < 3000; n++) begin
      logic [15:0] wd, da;
      logic [17:0] ia;
      if ((n % 50) == 0) seg_valid = {$urandom, $urandom, $urandom, $urandom};
      wd = 16'($urandom);
      if ($urandom_range(0, 1) == 1) wd[12] = 1'b0;
      case ($urandom_range(0, 3))
        0: da = 16'($urandom_range(0, 16'h7FFF));
        1: da = 16'($urandom_range(16'hC000, 16'hFFFF));
        2: da = {12'hFF0, 4'($urandom)};
        default: da = 16'($urandom_range(16'h8000, 16'hBFFF));
      endcase
      ia = 18'($urandom);
      step($urandom_range(0, 3) != 0, 2'($urandom), wd, da, ia, "");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule